// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a clocked model of the read side of a 16-bit read-only store. The store can also be read one byte at a time. An active-low select and an active-low output enable gate the port. A width input picks whole-word reads or byte reads. In byte mode, a separate pin, `byte_lsb`, serves as the lowest address bit and picks which half of the addressed word appears on the low eight data lines. The bus has no tristate. Two enables, one per data half, mark which half is driven, and any undriven half reads as zero.

An identify request makes the port return fixed codes instead of array data. Address bit 0 chooses the code: 0 gives the maker code and 1 gives the part code. Every other address bit must be zero. If one is not, the port returns all ones and raises an error flag. The array powers up and resets to all ones, the erased state. A test-only write port can load it.

One process holds the mode state and one drives the outputs. The states are STANDBY, OFF, WORD, BYTE_LO, BYTE_HI, ID_MAKER, ID_PART and ID_BAD. After each clock edge, the next state is chosen from the inputs in this order of priority:
- `ce_n` high gives STANDBY.
- Otherwise `oe_n` high gives OFF.
- Otherwise `id_req` gives ID_BAD if any upper address bit is set, else ID_PART or ID_MAKER according to `addr[0]`.
- Otherwise `word_mode` gives WORD.
- Otherwise `byte_lsb` gives BYTE_HI or BYTE_LO.

Every transition between any two states is possible on any edge. Outputs show the inputs sampled at the previous rising edge, so the read latency is one cycle.

Top module: `dual_rom_port`

## Requirements
- R1: During reset and in the first cycle after it, both enables and `id_err` are low and `dout` is zero. Reset sets every array word to 16'hFFFF.
- R2: When `ce_n` was high at the previous edge, both enables are low and `dout` is zero, whatever `oe_n`, `id_req` or the other inputs were.
- R3: When `ce_n` was low and `oe_n` high at the previous edge, both enables are low and `dout` is zero.
- R4: In a word read (`word_mode`=1), `dout` is the addressed word, `oe_lo`=`oe_hi`=1, one cycle after the address is sampled.
- R5: In a byte read (`word_mode`=0), `dout[7:0]` is the upper byte (bits 15:8) of the addressed word when `byte_lsb`=1 and the lower byte when `byte_lsb`=0.
- R6: In a byte read, `oe_lo`=1, `oe_hi`=0 and `dout[15:8]` is zero.
- R7: With `id_req`=1 and `addr`=0, `dout` is 16'h00C2 with both enables high, regardless of `word_mode` and the array contents.
- R8: With `id_req`=1, `addr[0]`=1 and all other address bits zero, `dout` is 16'hB800 with both enables high.
- R9: With `id_req`=1 and any of `addr[AW-1:1]` set, `dout` is 16'hFFFF, both enables are high and `id_err`=1. At all other times `id_err`=0.
- R10: A write (`tw_en`=1) stores `tw_data` at `tw_addr` at the edge. A read of that word sampled at a later edge returns the new value. A read sampled at the same edge returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low select; high means standby |
| oe_n | input | 1 | Active-low output enable |
| word_mode | input | 1 | 1 = 16-bit reads, 0 = byte reads |
| addr | input | AW | Word address |
| byte_lsb | input | 1 | Byte-mode half select (1 = upper byte) |
| id_req | input | 1 | Identify request |
| tw_en | input | 1 | Test write strobe |
| tw_addr | input | AW | Test write address |
| tw_data | input | 16 | Test write data |
| dout | output | 16 | Read data, zero where not enabled |
| oe_lo | output | 1 | Bits 7:0 driven |
| oe_hi | output | 1 | Bits 15:8 driven |
| id_err | output | 1 | Identify request with illegal address |

## Verification
The bench builds the block with the default depth of 16 words, so AW is 4. At that size the directed phase can write and read back every word. It can also reach each of the three upper address bits on its own, so the identify legality check sees every bit that can invalidate it. A long random phase mixes selects, widths, identify requests and writes against a behavioural model, one comparison per clock. That phase covers transitions between every pair of states and the case where a read and a write hit the same word at the same edge.

// File: rtl/dual_rom_pkg.sv
package dual_rom_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_OFF     = 3'd1,
        ST_WORD    = 3'd2,
        ST_BYTE_LO = 3'd3,
        ST_BYTE_HI = 3'd4,
        ST_ID_MAKER = 3'd5,
        ST_ID_PART = 3'd6,
        ST_ID_BAD  = 3'd7
    } port_state_t;

    localparam logic [15:0] MAKER_CODE = 16'h00C2;
    localparam logic [15:0] PART_CODE  = 16'hB800;
    localparam logic [15:0] ERASED     = 16'hFFFF;
endpackage

// File: rtl/dual_rom_store.sv
module dual_rom_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] cells [DEPTH];

    // Storage: erased to all ones on reset, loaded by the test write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Registered read; sees the contents before a same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '1;
        end else begin
            rd_q <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/dual_rom_mode_fsm.sv
module dual_rom_mode_fsm
    import dual_rom_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          word_mode,
    input  logic          byte_lsb,
    input  logic          id_req,
    input  logic [AW-1:0] addr,
    output port_state_t   state
);
    port_state_t state_nx;
    logic        upper_set;

    generate
        if (AW > 1) begin : g_upper
            assign upper_set = |addr[AW-1:1];
        end else begin : g_noupper
            assign upper_set = 1'b0;
        end
    endgenerate

    always_comb begin
        state_nx = ST_STANDBY;
        if (ce_n) begin
            state_nx = ST_STANDBY;
        end else if (oe_n) begin
            state_nx = ST_OFF;
        end else if (id_req) begin
            if (upper_set) begin
                state_nx = ST_ID_BAD;
            end else if (addr[0]) begin
                state_nx = ST_ID_PART;
            end else begin
                state_nx = ST_ID_MAKER;
            end
        end else if (word_mode) begin
            state_nx = ST_WORD;
        end else if (byte_lsb) begin
            state_nx = ST_BYTE_HI;
        end else begin
            state_nx = ST_BYTE_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/dual_rom_out.sv
module dual_rom_out
    import dual_rom_pkg::*;
(
    input  port_state_t state,
    input  logic [15:0] rd_q,
    output logic [15:0] dout,
    output logic        oe_lo,
    output logic        oe_hi,
    output logic        id_err
);
    always_comb begin
        dout   = '0;
        oe_lo  = 1'b0;
        oe_hi  = 1'b0;
        id_err = 1'b0;
        unique case (state)
            ST_STANDBY, ST_OFF: begin
                dout = '0;
            end
            ST_WORD: begin
                dout  = rd_q;
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            ST_BYTE_LO: begin
                dout  = {8'h00, rd_q[7:0]};
                oe_lo = 1'b1;
            end
            ST_BYTE_HI: begin
                dout  = {8'h00, rd_q[15:8]};
                oe_lo = 1'b1;
            end
            ST_ID_MAKER: begin
                dout  = MAKER_CODE;
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            ST_ID_PART: begin
                dout  = PART_CODE;
                oe_lo = 1'b1;
                oe_hi = 1'b1;
            end
            ST_ID_BAD: begin
                dout   = ERASED;
                oe_lo  = 1'b1;
                oe_hi  = 1'b1;
                id_err = 1'b1;
            end
            default: begin
                dout = '0;
            end
        endcase
    end
endmodule

// File: rtl/dual_rom_port.sv
module dual_rom_port
    import dual_rom_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          word_mode,
    input  logic [AW-1:0] addr,
    input  logic          byte_lsb,
    input  logic          id_req,
    input  logic          tw_en,
    input  logic [AW-1:0] tw_addr,
    input  logic [15:0]   tw_data,
    output logic [15:0]   dout,
    output logic          oe_lo,
    output logic          oe_hi,
    output logic          id_err
);
    port_state_t   state;
    logic [15:0]   rd_q;

    dual_rom_store #(.DEPTH(DEPTH), .DW(16)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr),
        .wr_en   (tw_en),
        .wr_addr (tw_addr),
        .wr_data (tw_data),
        .rd_q    (rd_q)
    );

    dual_rom_mode_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .word_mode (word_mode),
        .byte_lsb  (byte_lsb),
        .id_req    (id_req),
        .addr      (addr),
        .state     (state)
    );

    dual_rom_out u_out (
        .state  (state),
        .rd_q   (rd_q),
        .dout   (dout),
        .oe_lo  (oe_lo),
        .oe_hi  (oe_hi),
        .id_err (id_err)
    );
endmodule

// File: rtl/dual_rom_port_chk.sv
module dual_rom_port_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          word_mode,
    input logic [AW-1:0] addr,
    input logic          id_req,
    input logic [15:0]   dout,
    input logic          oe_lo,
    input logic          oe_hi,
    input logic          id_err
);
    logic started;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    // R1: nothing is driven before the first sampled edge after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!oe_lo && !oe_hi && !id_err && dout == 16'h0000));

    // R2: standby turns both halves off
    a_r2_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(ce_n)) |-> (!oe_lo && !oe_hi && dout == 16'h0000));

    // R3: output enable high turns both halves off
    a_r3_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(!ce_n && oe_n)) |-> (!oe_lo && !oe_hi));

    // R6: upper half never driven without the lower half, and idle upper bits are zero
    a_r6_upper_needs_lower: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi |-> oe_lo);
    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(!ce_n && !oe_n && !id_req && !word_mode))
            |-> (oe_lo && !oe_hi && dout[15:8] == 8'h00));

    // R7: maker code at identify address zero
    a_r7_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(!ce_n && !oe_n && id_req && addr == '0))
            |-> (dout == 16'h00C2 && oe_hi));

    // R9: error flag only with all ones on a driven bus
    a_r9_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> (dout == 16'hFFFF && oe_lo && oe_hi));
    a_r9_err_needs_id: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(!id_req)) |-> !id_err);
endmodule

bind dual_rom_port dual_rom_port_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .word_mode (word_mode),
    .addr      (addr),
    .id_req    (id_req),
    .dout      (dout),
    .oe_lo     (oe_lo),
    .oe_hi     (oe_hi),
    .id_err    (id_err)
);

// File: tb/dual_rom_port_tb.sv
`timescale 1ns/1ps
module dual_rom_port_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, word_mode, byte_lsb, id_req, tw_en;
    logic [AW-1:0] addr, tw_addr;
    logic [15:0]   tw_data;
    logic [15:0]   dout;
    logic          oe_lo, oe_hi, id_err;

    int checks = 0;
    int errors = 0;

    logic [15:0] mdl [DEPTH];
    logic [15:0] e_dout;
    logic        e_lo, e_hi, e_err;
    string       e_tag;

    always #10 clk = ~clk;

    dual_rom_port #(.DEPTH(DEPTH)) u_dut (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n),
        .word_mode (word_mode), .addr (addr), .byte_lsb (byte_lsb),
        .id_req (id_req), .tw_en (tw_en), .tw_addr (tw_addr),
        .tw_data (tw_data), .dout (dout), .oe_lo (oe_lo),
        .oe_hi (oe_hi), .id_err (id_err)
    );

    // Expected output for the inputs currently applied, then model update.
    task automatic predict();
        e_dout = 16'h0000; e_lo = 1'b0; e_hi = 1'b0; e_err = 1'b0;
        if (!rst_n) begin
            e_tag = "R1";
        end else if (ce_n) begin
            e_tag = "R2";
        end else if (oe_n) begin
            e_tag = "R3";
        end else if (id_req) begin
            e_lo = 1'b1; e_hi = 1'b1;
            if (addr >> 1 != 0) begin
                e_tag = "R9"; e_dout = 16'hFFFF; e_err = 1'b1;
            end else if (addr[0]) begin
                e_tag = "R8"; e_dout = 16'hB800;
            end else begin
                e_tag = "R7"; e_dout = 16'h00C2;
            end
        end else if (word_mode) begin
            e_tag = "R4"; e_lo = 1'b1; e_hi = 1'b1; e_dout = mdl[addr];
        end else begin
            e_tag = "R5"; e_lo = 1'b1;
            e_dout = byte_lsb ? {8'h00, mdl[addr][15:8]} : {8'h00, mdl[addr][7:0]};
        end
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        end else if (tw_en) begin
            mdl[tw_addr] = tw_data;
        end
    endtask

    task automatic check_now();
        checks++;
        if (dout !== e_dout || oe_lo !== e_lo || oe_hi !== e_hi || id_err !== e_err) begin
            errors++;
            $display("FAIL %s: dout=%h lo=%b hi=%b err=%b expected dout=%h lo=%b hi=%b err=%b",
                     e_tag, dout, oe_lo, oe_hi, id_err, e_dout, e_lo, e_hi, e_err);
        end
        if (e_tag == "R5" && rst_n) begin
            checks++;
            if (oe_hi !== 1'b0 || dout[15:8] !== 8'h00) begin
                errors++;
                $display("FAIL R6: hi=%b upper=%h expected hi=0 upper=00", oe_hi, dout[15:8]);
            end
        end
    endtask

    // Inputs are set after a falling edge; one rising edge later the result is sampled.
    task automatic tick();
        predict();
        @(negedge clk);
        check_now();
    endtask

    task automatic set_in(input logic c, input logic o, input logic w, input logic b,
                          input logic idq, input int a);
        ce_n = c; oe_n = o; word_mode = w; byte_lsb = b; id_req = idq;
        addr = AW'(a); tw_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        tw_en = 1'b1; tw_addr = AW'(a); tw_data = d;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tw_addr = '0; tw_data = '0;
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h0000;
        @(negedge clk);
        tick(); tick();                          // R1 during reset
        rst_n = 1'b1;
        // R1: first cycle after reset still quiet (state reset), then erased read
        e_tag = "R1"; e_dout = 16'h0000; e_lo = 0; e_hi = 0; e_err = 0;
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3);
        tick();                                  // R1: erased word reads all ones
        // R10: load every word while in standby
        for (int i = 0; i < DEPTH; i++) begin
            set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, i);
            wr(i, 16'h1000 * i[3:0] + 16'h0A5 + 16'h11 * i[3:0]);
            tick();                              // R2 standby while writing
        end
        for (int i = 0; i < DEPTH; i++) begin
            set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, i);
            tick();                              // R4, R10 readback
        end
        for (int i = 0; i < 4; i++) begin
            set_in(1'b0, 1'b0, 1'b0, i[0], 1'b0, i + 2);
            tick();                              // R5, R6 byte halves
        end
        set_in(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2); tick();   // R3
        set_in(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 0); tick();   // R2 with identify held
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0); tick();   // R7
        set_in(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0); tick();   // R7 byte width ignored
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1); tick();   // R8
        for (int b = 1; b < AW; b++) begin
            set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1 << b);
            tick();                              // R9 each upper bit
        end
        // R10: same-edge read returns old data, next edge new data
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5); wr(5, 16'h5A5A); tick();
        set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5); tick();
        // random phase
        for (int n = 0; n < 2000; n++) begin
            set_in(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 3) == 0),
                   ($urandom_range(0, 1) == 1) ? $urandom_range(0, 1) : $urandom_range(0, DEPTH - 1));
            if ($urandom_range(0, 3) == 0) wr($urandom_range(0, DEPTH - 1), 16'($urandom));
            tick();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule